// File: doc/BRIEF.md
# Address Strap Decoder with Power-Up Defaults

This block works out how two address-select pins are strapped and turns the result into a slave address and a set of per-port defaults. A pin can be wired to ground, to supply, to the serial data line or to the serial clock line. The decoder compares each pin with both bus lines while a transmission is in progress. It does this for every transmission on the bus, whether or not the device is the target. A rewired strap therefore takes effect at the next transmission, without a power cycle.

Each strap resolves to one of four classes. The two classes together select three things: the low field of a 7-bit slave address, pull-up enables for two groups of four input ports, and default output levels for all sixteen ports. The classes are latched at the ninth rising clock of the byte that follows a start. Until the first such byte has been decoded, neither strap can be told apart from a fixed level. In that interval each strap is taken as ground or supply, following its live pin level.

Top module: `strap_decoder`

## Requirements
- R1: While reset is held and just after it is released, `decode_valid` is 0. Every other output then follows R2.
- R2: While `decode_valid` is 0, each strap is classed as GND (code 0) when its pin reads 0 and as VCC (code 1) when it reads 1, following the live pin. Pull-up group k is then equal to strap k's pin level.
- R3: A strap that equals SCL on every cycle from the cycle after the start strobe up to and including the latching cycle is classed as SCL (code 3).
- R4: A strap not classed as SCL is classed as SDA (code 2) only if it equals SDA on every sampled cycle and SDA changed at least once while SCL held steady. Without such a change it takes its level at the latching cycle.
- R5: `slave_addr` = {3'b110, idx ^ 4'b0101}, where idx = class1*4 + class0.
- R6: Pull-up bits 4k..4k+3 are all 1 exactly when strap k is classed VCC or SCL.
- R7: Default levels of ports 0..7 equal the pull-up bits. Ports 8+4k..11+4k default high exactly when strap k is classed VCC or SDA.
- R8: At the 9th rising SCL sample after a start strobe, the classes are latched. They appear on the outputs one clock later, and `decode_valid` rises at that same time and then stays 1.
- R9: Each later transmission re-decodes the straps, so the address can change without a reset.
- R10: A start strobe in the same cycle as the 9th rising SCL sample restarts the frame, and nothing is latched.
- R11: A frame with fewer than 9 SCL rises leaves the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| strap_i | input | 2 | Sampled levels of the two strap pins |
| sda_i | input | 1 | Sampled serial data line |
| scl_i | input | 1 | Sampled serial clock line |
| start_i | input | 1 | One-cycle start-condition strobe |
| slave_addr | output | 7 | Decoded slave address |
| port_dflt | output | 16 | Power-up output level of each port |
| pullup_en | output | 8 | Pull-up enable of each input port |
| decode_valid | output | 1 | A full address byte has been decoded |

## Verification
Two functions can land in the same cycle: a start strobe that opens a new frame, and the 9th rising clock that closes the current one. The bench drives the start strobe exactly on the 9th high phase of the address byte. It then checks that `decode_valid` stays low and that the outputs still follow the live pin levels rather than a latched class. It also sweeps all sixteen strap combinations through complete frames and compares every output with arithmetic expectations.

// File: rtl/strap_dec_pkg.sv
package strap_dec_pkg;

   typedef enum logic [1:0] {
      STRAP_GND = 2'd0,
      STRAP_VCC = 2'd1,
      STRAP_SDA = 2'd2,
      STRAP_SCL = 2'd3
   } strap_cls_e;

   function automatic logic cls_pullup(strap_cls_e c);
      return (c == STRAP_VCC) || (c == STRAP_SCL);
   endfunction

   function automatic logic cls_level(strap_cls_e c);
      return (c == STRAP_VCC) || (c == STRAP_SDA);
   endfunction

endpackage

// File: rtl/strap_frame_trk.sv
module strap_frame_trk #(
   parameter int BYTE_CLKS = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_i,
   input  logic scl_i,
   input  logic start_i,
   output logic active_o,
   output logic sda_tog_o,
   output logic latch_o
);
   localparam int CNT_W = $clog2(BYTE_CLKS + 1);

   logic             scl_q, sda_q, active_q;
   logic [CNT_W-1:0] cnt_q;
   logic             scl_rise, last_clk;

   assign scl_rise  = scl_i & ~scl_q;
   assign sda_tog_o = (sda_i ^ sda_q) & ~(scl_i ^ scl_q);
   assign last_clk  = (cnt_q == CNT_W'(BYTE_CLKS - 1));
   assign latch_o   = active_q & scl_rise & last_clk & ~start_i;
   assign active_o  = active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else begin
         scl_q <= scl_i;
         sda_q <= sda_i;
         if (start_i) begin
            active_q <= 1'b1;
            cnt_q    <= '0;
         end else if (active_q && scl_rise) begin
            if (last_clk) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else begin
               cnt_q <= cnt_q + CNT_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
   import strap_dec_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       strap_i,
   input  logic       sda_i,
   input  logic       scl_i,
   input  logic       start_i,
   input  logic       active_i,
   input  logic       sda_tog_i,
   input  logic       latch_i,
   output strap_cls_e cls_o
);
   logic       miss_scl_q, miss_sda_q, tog_q;
   logic       miss_scl_n, miss_sda_n, tog_n;
   strap_cls_e cls_q, cls_n;

   assign miss_scl_n = miss_scl_q | (strap_i ^ scl_i);
   assign miss_sda_n = miss_sda_q | (strap_i ^ sda_i);
   assign tog_n      = tog_q | sda_tog_i;

   always_comb begin
      if (!miss_scl_n)             cls_n = STRAP_SCL;
      else if (!miss_sda_n && tog_n) cls_n = STRAP_SDA;
      else if (strap_i)            cls_n = STRAP_VCC;
      else                         cls_n = STRAP_GND;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         miss_scl_q <= 1'b0;
         miss_sda_q <= 1'b0;
         tog_q      <= 1'b0;
         cls_q      <= STRAP_GND;
      end else begin
         if (start_i) begin
            miss_scl_q <= 1'b0;
            miss_sda_q <= 1'b0;
            tog_q      <= 1'b0;
         end else if (active_i) begin
            miss_scl_q <= miss_scl_n;
            miss_sda_q <= miss_sda_n;
            tog_q      <= tog_n;
         end
         if (latch_i) cls_q <= cls_n;
      end
   end

   assign cls_o = cls_q;
endmodule

// File: rtl/strap_map.sv
module strap_map
   import strap_dec_pkg::*;
#(
   parameter int NUM_STRAPS = 2,
   parameter int GROUP_W    = 4,
   parameter int ADDR_W     = 7,
   parameter logic [ADDR_W-2*NUM_STRAPS-1:0] ADDR_HI  = 3'b110,
   parameter logic [2*NUM_STRAPS-1:0]        ADDR_XOR = 4'b0101
) (
   input  strap_cls_e [NUM_STRAPS-1:0]   cls_i,
   output logic [ADDR_W-1:0]             addr_o,
   output logic [NUM_STRAPS*GROUP_W-1:0] pull_o,
   output logic [2*NUM_STRAPS*GROUP_W-1:0] dflt_o
);
   localparam int IDX_W  = 2 * NUM_STRAPS;
   localparam int PULL_W = NUM_STRAPS * GROUP_W;

   logic [IDX_W-1:0] idx;

   for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_grp
      assign idx[2*k +: 2]                    = cls_i[k];
      assign pull_o[k*GROUP_W +: GROUP_W]     = {GROUP_W{cls_pullup(cls_i[k])}};
      assign dflt_o[PULL_W + k*GROUP_W +: GROUP_W] = {GROUP_W{cls_level(cls_i[k])}};
   end

   assign dflt_o[PULL_W-1:0] = pull_o;
   assign addr_o             = {ADDR_HI, idx ^ ADDR_XOR};
endmodule

// File: rtl/strap_decoder.sv
module strap_decoder
   import strap_dec_pkg::*;
#(
   parameter int NUM_STRAPS = 2,
   parameter int GROUP_W    = 4,
   parameter int ADDR_W     = 7,
   parameter int BYTE_CLKS  = 9,
   parameter logic [ADDR_W-2*NUM_STRAPS-1:0] ADDR_HI  = 3'b110,
   parameter logic [2*NUM_STRAPS-1:0]        ADDR_XOR = 4'b0101
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_STRAPS-1:0]           strap_i,
   input  logic                            sda_i,
   input  logic                            scl_i,
   input  logic                            start_i,
   output logic [ADDR_W-1:0]               slave_addr,
   output logic [2*NUM_STRAPS*GROUP_W-1:0] port_dflt,
   output logic [NUM_STRAPS*GROUP_W-1:0]   pullup_en,
   output logic                            decode_valid
);
   if (NUM_STRAPS < 1 || NUM_STRAPS > 3) begin : g_bad_straps
      $error("strap_decoder: NUM_STRAPS must be 1..3");
   end
   if (ADDR_W <= 2 * NUM_STRAPS) begin : g_bad_addr
      $error("strap_decoder: ADDR_W must exceed the strap field");
   end
   if (GROUP_W < 1 || BYTE_CLKS < 2) begin : g_bad_misc
      $error("strap_decoder: GROUP_W >= 1 and BYTE_CLKS >= 2 required");
   end

   logic active, sda_tog, latch, valid_q;
   strap_cls_e [NUM_STRAPS-1:0] cls_lat, cls_eff;

   strap_frame_trk #(.BYTE_CLKS(BYTE_CLKS)) i_trk (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_i    (sda_i),
      .scl_i    (scl_i),
      .start_i  (start_i),
      .active_o (active),
      .sda_tog_o(sda_tog),
      .latch_o  (latch)
   );

   for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_strap
      strap_classifier i_cls (
         .clk      (clk),
         .rst_n    (rst_n),
         .strap_i  (strap_i[k]),
         .sda_i    (sda_i),
         .scl_i    (scl_i),
         .start_i  (start_i),
         .active_i (active),
         .sda_tog_i(sda_tog),
         .latch_i  (latch),
         .cls_o    (cls_lat[k])
      );
      assign cls_eff[k] = valid_q ? cls_lat[k]
                                  : (strap_i[k] ? STRAP_VCC : STRAP_GND);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     valid_q <= 1'b0;
      else if (latch) valid_q <= 1'b1;
   end

   strap_map #(
      .NUM_STRAPS(NUM_STRAPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W),
      .ADDR_HI(ADDR_HI), .ADDR_XOR(ADDR_XOR)
   ) i_map (
      .cls_i (cls_eff),
      .addr_o(slave_addr),
      .pull_o(pullup_en),
      .dflt_o(port_dflt)
   );

   assign decode_valid = valid_q;
endmodule

// File: rtl/strap_decoder_chk.sv
module strap_decoder_chk #(
   parameter int NUM_STRAPS = 2,
   parameter int GROUP_W    = 4,
   parameter int ADDR_W     = 7,
   parameter logic [ADDR_W-2*NUM_STRAPS-1:0] ADDR_HI = 3'b110
) (
   input logic                            clk,
   input logic                            rst_n,
   input logic [NUM_STRAPS-1:0]           strap_i,
   input logic                            scl_i,
   input logic                            start_i,
   input logic [ADDR_W-1:0]               slave_addr,
   input logic [2*NUM_STRAPS*GROUP_W-1:0] port_dflt,
   input logic [NUM_STRAPS*GROUP_W-1:0]   pullup_en,
   input logic                            decode_valid
);
   localparam int PULL_W = NUM_STRAPS * GROUP_W;
   localparam int HI_W   = ADDR_W - 2 * NUM_STRAPS;

   assert_valid_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      decode_valid |=> decode_valid);

   assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(decode_valid) |-> ($past(scl_i) && !$past(start_i)));

   assert_addr_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      slave_addr[ADDR_W-1 -: HI_W] == ADDR_HI);

   assert_input_dflt_R7: assert property (@(posedge clk) disable iff (!rst_n)
      port_dflt[PULL_W-1:0] == pullup_en);

   assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (decode_valid && $past(decode_valid) && !$past(scl_i))
      |-> ($stable(slave_addr) && $stable(pullup_en) && $stable(port_dflt)));

   for (genvar k = 0; k < NUM_STRAPS; k++) begin : g_pre
      assert_static_pull_R2: assert property (@(posedge clk) disable iff (!rst_n)
         !decode_valid |-> (pullup_en[k*GROUP_W +: GROUP_W] == {GROUP_W{strap_i[k]}}));
   end
endmodule

bind strap_decoder strap_decoder_chk #(
   .NUM_STRAPS(NUM_STRAPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W), .ADDR_HI(ADDR_HI)
) i_strap_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .strap_i     (strap_i),
   .scl_i       (scl_i),
   .start_i     (start_i),
   .slave_addr  (slave_addr),
   .port_dflt   (port_dflt),
   .pullup_en   (pullup_en),
   .decode_valid(decode_valid)
);

// File: tb/test_strap_decoder.sv
`timescale 1ns/1ps
module test_strap_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  strap_r = 2'b00;
   logic        sda_r = 1'b1, scl_r = 1'b1, start_r = 1'b0;
   logic [6:0]  slave_addr;
   logic [15:0] port_dflt;
   logic [7:0]  pullup_en;
   logic        decode_valid;
   int          checks = 0, errors = 0;
   int          m0 = 0, m1 = 0;   // pin wiring: 0 GND, 1 VCC, 2 SDA, 3 SCL

   always #2.5 clk = ~clk;

   strap_decoder i_strap_decoder (
      .clk(clk), .rst_n(rst_n), .strap_i(strap_r), .sda_i(sda_r), .scl_i(scl_r),
      .start_i(start_r), .slave_addr(slave_addr), .port_dflt(port_dflt),
      .pullup_en(pullup_en), .decode_valid(decode_valid)
   );

   function automatic logic pin(int m);
      case (m)
         0: return 1'b0;
         1: return 1'b1;
         2: return sda_r;
         default: return scl_r;
      endcase
   endfunction

   task automatic step(input logic sda, input logic scl, input logic st);
      sda_r = sda; scl_r = scl; start_r = st;
      strap_r[0] = pin(m0);
      strap_r[1] = pin(m1);
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected outputs from class codes c0, c1 and expected valid
   task automatic check_all(input string req, input int c0, input int c1, input logic v);
      logic [3:0]  idx;
      logic [7:0]  pull;
      logic [15:0] dflt;
      logic        p0, p1, l0, l1;
      idx  = 4'(c1 * 4 + c0);
      p0 = (c0 == 1 || c0 == 3); p1 = (c1 == 1 || c1 == 3);
      l0 = (c0 == 1 || c0 == 2); l1 = (c1 == 1 || c1 == 2);
      pull = {{4{p1}}, {4{p0}}};
      dflt = {{4{l1}}, {4{l0}}, pull};
      chk({req, " valid"},  32'(decode_valid), 32'(v));
      chk({req, " addr R5"}, 32'(slave_addr),  32'({3'b110, idx ^ 4'b0101}));
      chk({req, " pull R6"}, 32'(pullup_en),   32'(pull));
      chk({req, " dflt R7"}, 32'(port_dflt),   32'(dflt));
   endtask

   logic prev_bit;
   task automatic frame(input logic [7:0] b, input logic ack, input bit collide, input int nclk);
      step(1'b1, 1'b1, 1'b0);
      step(1'b0, 1'b1, 1'b1);
      prev_bit = 1'b0;
      for (int i = 0; i < nclk; i++) begin
         logic bt;
         bt = (i < 8) ? b[7-i] : ack;
         step(prev_bit, 1'b0, 1'b0);
         step(bt, 1'b0, 1'b0);
         step(bt, 1'b1, collide && (i == nclk - 1));
         prev_bit = bt;
      end
   endtask

   task automatic tail();
      step(prev_bit, 1'b0, 1'b0);
      step(1'b0, 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0);
      step(1'b1, 1'b1, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      m0 = 1; m1 = 0;
      step(1'b1, 1'b1, 1'b0);
      rst_n = 1'b0;
      step(1'b1, 1'b1, 1'b0);
      check_all("R1 in reset", 1, 0, 1'b0);
      rst_n = 1'b1;
      step(1'b1, 1'b1, 1'b0);
      check_all("R1 after reset", 1, 0, 1'b0);

      // R2: live static levels before first decode
      for (int s = 0; s < 4; s++) begin
         m0 = s & 1; m1 = (s >> 1) & 1;
         step(1'b1, 1'b1, 1'b0);
         check_all("R2 static pre-valid", m0, m1, 1'b0);
      end

      // R10: start on the 9th rise restarts, nothing latched; live pins seen as levels
      m0 = 3; m1 = 2;
      frame(8'hA5, 1'b0, 1'b1, 9);
      check_all("R10 start on 9th rise", 1, 0, 1'b0);
      tail();

      // R3/R5/R6/R7/R8/R9: all sixteen wirings through full frames
      for (int c = 0; c < 16; c++) begin
         m0 = c % 4; m1 = c / 4;
         frame(8'hA5, 1'b0, 1'b0, 9);
         check_all("R8 R3 R9 sweep", m0, m1, 1'b1);
         tail();
         check_all("R9 held after frame", m0, m1, 1'b1);
      end

      // R4: SDA-tied with no SDA change under steady SCL -> level at latch (0)
      m0 = 2; m1 = 2;
      frame(8'h00, 1'b0, 1'b0, 9);
      check_all("R4 no toggle", 0, 0, 1'b1);
      tail();
      frame(8'h3C, 1'b0, 1'b0, 9);
      check_all("R4 with toggle", 2, 2, 1'b1);
      tail();

      // R11: short frame leaves previous decode
      m0 = 1; m1 = 3;
      frame(8'hA5, 1'b0, 1'b0, 9);
      tail();
      m0 = 0; m1 = 2;
      frame(8'hA5, 1'b0, 1'b0, 5);
      check_all("R11 short frame", 1, 3, 1'b1);
      tail();
      check_all("R11 after short frame", 1, 3, 1'b1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule